// File: doc/BRIEF.md
# PLL Lock Monitor with Single Reset Retry

This block decides whether a PHY PLL has locked once the PHY power-up sequence has finished. After a start pulse it takes the PLL lock input as a sample on each microsecond tick. A polling window is a bounded number of such samples. If a window runs out with no lock seen, the block pulls the PLL reset-bar override low and then releases it. It then opens a second window of the same length. If the second window also runs out, it declares failure.

On either outcome the block moves the port-control field to its non-drive-low value and raises done, together with exactly one of pass or fail. These results hold until the next start. A super-speed path option adds a stabilisation wait of a fixed number of ticks before the first sample. During that wait reset-bar is already released. The tick comes from a shared timebase, and the lock signal comes straight from the PLL.

Top module: `pll_lock_mon`

## Requirements
- R1: During and after reset, pll_rstb_o is 0, pctl_o equals PCTL_RUN (default 2'b11), and done_o, pass_o and fail_o are 0.
- R2: A start_i pulse in the idle or done state sets pll_rstb_o to 1, restores pctl_o to PCTL_RUN and clears done_o, pass_o and fail_o on the next cycle. A start_i pulse while a check is in progress has no effect.
- R3: lock_i is sampled only in cycles where tick_i is 1. In the non-super-speed case the first sample is the first tick after start. The first sample with lock_i at 1 gives pass_o=1 and done_o=1 on the next cycle.
- R4: After RETRY consecutive samples with lock_i at 0 in the first window, pll_rstb_o goes to 0 on the next cycle. It stays 0 until the next tick, returns to 1 after that tick (which is not a sample), and a fresh window of RETRY samples begins.
- R5: If the second window also ends with RETRY samples without lock, fail_o=1 and done_o=1 on the next cycle, and pll_rstb_o never goes low a second time.
- R6: pass_o and fail_o are never 1 together. While done, they hold their values until the next start.
- R7: Whenever done_o is 1, pctl_o equals PCTL_NDL (default 2'b01). This applies to both pass and fail.
- R8: With ss_path_i=1 at start (and SS_EN=1), the first STAB_TICKS ticks are a stabilisation wait with lock_i ignored. The first sample is tick STAB_TICKS+1.
- R9: When lock_i is 1 on the last sample of a window, pass takes priority over the timeout, and no reset toggle or failure follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a lock check |
| ss_path_i | input | 1 | Select the super-speed path with stabilisation wait (captured at start) |
| lock_i | input | 1 | PLL lock indication |
| tick_i | input | 1 | One-cycle microsecond tick |
| pll_rstb_o | output | 1 | PLL reset-bar override, active low |
| pctl_o | output | PCTL_W | Port-control mode field |
| done_o | output | 1 | Check finished |
| pass_o | output | 1 | PLL found locked |
| fail_o | output | 1 | PLL never locked in both windows |

## Verification
The two functions that can fall in one cycle are the lock detection and the window timeout. Both can fire on the final sample of a window, and the design must resolve that sample as a pass. The bench provokes this by holding lock low through RETRY-1 ticks and raising it exactly on the RETRY-th tick. It then judges that pass is set, fail is clear and reset-bar never fell. A busy-time start pulse that coincides with polling is also driven, to confirm that it neither restarts the window nor selects the stabilisation path.

// File: rtl/plm_pkg.sv
package plm_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETTLE,
        PH_POLL,
        PH_RSTLO,
        PH_DONE
    } plm_phase_e;

    typedef struct packed {
        logic pass;
        logic fail;
    } plm_verdict_t;

    function automatic int plm_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/plm_tick_cnt.sv
module plm_tick_cnt #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/plm_seq.sv
module plm_seq
    import plm_pkg::*;
#(
    parameter int              RETRY      = 100,
    parameter int              STAB_TICKS = 1000,
    parameter int              CW         = 11,
    parameter int              PCTL_W     = 2,
    parameter logic [PCTL_W-1:0] PCTL_RUN = 2'h3,
    parameter logic [PCTL_W-1:0] PCTL_NDL = 2'h1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              ss_sel_i,
    input  logic              lock_i,
    input  logic              tick_i,
    input  logic [CW-1:0]     cnt_i,
    output logic              cnt_clr_o,
    output logic              cnt_inc_o,
    output logic              pll_rstb_o,
    output logic [PCTL_W-1:0] pctl_o,
    output logic              done_o,
    output logic              pass_o,
    output logic              fail_o
);

    localparam logic [CW-1:0] POLL_LAST   = CW'(RETRY - 1);
    localparam logic [CW-1:0] SETTLE_LAST = CW'(STAB_TICKS - 1);

    plm_phase_e   state;
    plm_verdict_t verdict_q;
    logic         retried_q;
    logic         poll_to;
    logic         settle_to;
    logic         idle_like;

    always_comb begin
        poll_to   = (cnt_i == POLL_LAST);
        settle_to = (cnt_i == SETTLE_LAST);
        idle_like = (state == PH_IDLE) || (state == PH_DONE);
        cnt_clr_o = !((state == PH_POLL) || (state == PH_SETTLE))
                    || ((state == PH_SETTLE) && tick_i && settle_to);
        cnt_inc_o = tick_i && ((state == PH_SETTLE)
                    || ((state == PH_POLL) && !lock_i));
        done_o    = (state == PH_DONE);
        pass_o    = verdict_q.pass;
        fail_o    = verdict_q.fail;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= PH_IDLE;
            verdict_q  <= '0;
            retried_q  <= 1'b0;
            pll_rstb_o <= 1'b0;
            pctl_o     <= PCTL_RUN;
        end else begin
            case (state)
                PH_IDLE, PH_DONE: begin
                    if (start_i) begin
                        pll_rstb_o <= 1'b1;
                        verdict_q  <= '0;
                        retried_q  <= 1'b0;
                        pctl_o     <= PCTL_RUN;
                        state      <= ss_sel_i ? PH_SETTLE : PH_POLL;
                    end
                end
                PH_SETTLE: begin
                    if (tick_i && settle_to) begin
                        state <= PH_POLL;
                    end
                end
                PH_POLL: begin
                    if (tick_i) begin
                        if (lock_i) begin
                            verdict_q.pass <= 1'b1;
                            pctl_o         <= PCTL_NDL;
                            state          <= PH_DONE;
                        end else if (poll_to) begin
                            if (retried_q) begin
                                verdict_q.fail <= 1'b1;
                                pctl_o         <= PCTL_NDL;
                                state          <= PH_DONE;
                            end else begin
                                pll_rstb_o <= 1'b0;
                                retried_q  <= 1'b1;
                                state      <= PH_RSTLO;
                            end
                        end
                    end
                end
                PH_RSTLO: begin
                    if (tick_i) begin
                        pll_rstb_o <= 1'b1;
                        state      <= PH_POLL;
                    end
                end
                default: state <= PH_IDLE;
            endcase
        end
    end

    assert_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(pass_o && fail_o));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> ($stable(pass_o) && $stable(fail_o)));

    assert_pctl_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (pctl_o == PCTL_NDL));

    assert_window_R4: assert property (@(posedge clk) disable iff (rst)
        (state == PH_POLL) |-> (cnt_i <= POLL_LAST));

    assert_onefall_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(pll_rstb_o) |-> $past(!retried_q));

    assert_settle_R8: assert property (@(posedge clk) disable iff (rst)
        (state == PH_SETTLE) |=> !pass_o);

    assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (!idle_like && start_i) |=> (state != PH_SETTLE || $past(state) == PH_SETTLE));

endmodule

// File: rtl/pll_lock_mon.sv
module pll_lock_mon
    import plm_pkg::*;
#(
    parameter int                RETRY      = 100,
    parameter int                STAB_TICKS = 1000,
    parameter bit                SS_EN      = 1'b1,
    parameter int                PCTL_W     = 2,
    parameter logic [PCTL_W-1:0] PCTL_RUN   = 2'h3,
    parameter logic [PCTL_W-1:0] PCTL_NDL   = 2'h1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              ss_path_i,
    input  logic              lock_i,
    input  logic              tick_i,
    output logic              pll_rstb_o,
    output logic [PCTL_W-1:0] pctl_o,
    output logic              done_o,
    output logic              pass_o,
    output logic              fail_o
);

    localparam int CNT_MAX = plm_max(RETRY, STAB_TICKS);
    localparam int CW      = $clog2(CNT_MAX + 1);

    logic          ss_sel;
    logic          cnt_clr;
    logic          cnt_inc;
    logic [CW-1:0] cnt;

    generate
        if (SS_EN) begin : g_ss
            assign ss_sel = ss_path_i;
        end else begin : g_no_ss
            assign ss_sel = 1'b0;
        end
    endgenerate

    plm_tick_cnt #(
        .CW (CW)
    ) u_cnt (
        .clk (clk),
        .rst (rst),
        .clr (cnt_clr),
        .inc (cnt_inc),
        .cnt (cnt)
    );

    plm_seq #(
        .RETRY      (RETRY),
        .STAB_TICKS (STAB_TICKS),
        .CW         (CW),
        .PCTL_W     (PCTL_W),
        .PCTL_RUN   (PCTL_RUN),
        .PCTL_NDL   (PCTL_NDL)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .ss_sel_i   (ss_sel),
        .lock_i     (lock_i),
        .tick_i     (tick_i),
        .cnt_i      (cnt),
        .cnt_clr_o  (cnt_clr),
        .cnt_inc_o  (cnt_inc),
        .pll_rstb_o (pll_rstb_o),
        .pctl_o     (pctl_o),
        .done_o     (done_o),
        .pass_o     (pass_o),
        .fail_o     (fail_o)
    );

endmodule

// File: tb/pll_lock_mon_tb.sv
`timescale 1ns/1ps
module pll_lock_mon_tb;

    localparam int         RETRY = 5;
    localparam int         STAB  = 8;
    localparam logic [1:0] ACT   = 2'h3;
    localparam logic [1:0] NDL   = 2'h1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic ss = 1'b0;
    logic lock = 1'b0;
    logic tick = 1'b0;
    logic       pll_rstb, done, pass, fail;
    logic [1:0] pctl;

    int checks = 0;
    int errors = 0;
    int falls  = 0;
    int cyc_n  = 0;

    always #4 clk = ~clk;

    pll_lock_mon #(
        .RETRY (RETRY), .STAB_TICKS (STAB), .SS_EN (1'b1),
        .PCTL_W (2), .PCTL_RUN (ACT), .PCTL_NDL (NDL)
    ) u_dut (
        .clk (clk), .rst (rst), .start_i (start), .ss_path_i (ss),
        .lock_i (lock), .tick_i (tick), .pll_rstb_o (pll_rstb),
        .pctl_o (pctl), .done_o (done), .pass_o (pass), .fail_o (fail)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // behavioural reference: phase 0 idle, 1 wait, 2 sampling, 3 reset low, 4 finished
    int   m_ph = 0;
    int   m_n = 0;
    bit   m_again = 0;
    logic m_rstb = 0, m_pass = 0, m_fail = 0;
    logic [1:0] m_pctl = ACT;

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_n = 0; m_again = 0;
            m_rstb = 0; m_pass = 0; m_fail = 0; m_pctl = ACT;
        end else begin
            if ((m_ph == 0 || m_ph == 4) && start) begin
                m_rstb = 1; m_pass = 0; m_fail = 0; m_pctl = ACT;
                m_again = 0; m_n = 0; m_ph = ss ? 1 : 2;
            end else if (m_ph == 1 && tick) begin
                m_n++;
                if (m_n == STAB) begin m_n = 0; m_ph = 2; end
            end else if (m_ph == 2 && tick) begin
                if (lock) begin
                    m_pass = 1; m_pctl = NDL; m_ph = 4;
                end else begin
                    m_n++;
                    if (m_n == RETRY) begin
                        if (m_again) begin m_fail = 1; m_pctl = NDL; m_ph = 4; end
                        else begin m_rstb = 0; m_again = 1; m_ph = 3; end
                    end
                end
            end else if (m_ph == 3 && tick) begin
                m_rstb = 1; m_n = 0; m_ph = 2;
            end
        end
    end

    logic prev_rstb = 1'b0;
    always @(posedge clk) begin
        if (!rst && prev_rstb && !pll_rstb) falls++;
        prev_rstb <= pll_rstb;
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk(pll_rstb == m_rstb, "R4", "cycle rstb", pll_rstb, m_rstb);
            chk(pass == m_pass, "R3", "cycle pass", pass, m_pass);
            chk(fail == m_fail, "R5", "cycle fail", fail, m_fail);
            chk(done == (m_ph == 4), "R3", "cycle done", done, m_ph == 4);
            chk(pctl == m_pctl, "R7", "cycle pctl", pctl, m_pctl);
            chk(!(pass && fail), "R6", "exclusive", pass && fail, 0);
        end
    end

    always @(posedge clk) begin
        cyc_n++;
        if (cyc_n > 100000) begin
            errors++; checks++;
            $display("FAIL R3 watchdog actual=%0d expected=finish", cyc_n);
            $display("[TB] %0d tests run, %0d failed", checks, errors);
            $finish;
        end
    end

    task automatic do_tick(input logic lk);
        lock = lk; tick = 1'b0;
        repeat (3) @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic do_start(input logic ssv);
        ss = ssv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(pll_rstb == 0, "R1", "reset rstb", pll_rstb, 0);
        chk(pctl == ACT, "R1", "reset pctl", pctl, ACT);
        chk(!done && !pass && !fail, "R1", "reset flags", {done, pass, fail}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(pll_rstb == 0 && !done, "R1", "post-reset idle", pll_rstb, 0);

        // immediate lock
        falls = 0;
        do_start(1'b0);
        chk(pll_rstb == 1 && !done, "R2", "start releases", pll_rstb, 1);
        do_tick(1'b1);
        chk(pass && done && !fail, "R3", "first-sample pass", pass, 1);
        chk(pctl == NDL, "R7", "pctl after pass", pctl, NDL);

        // lock on third sample
        do_start(1'b0);
        chk(!pass && !done, "R2", "restart clears", pass, 0);
        do_tick(1'b0); do_tick(1'b0);
        chk(!done, "R3", "no lock yet", done, 0);
        do_tick(1'b1);
        chk(pass && falls == 0, "R3", "third-sample pass", pass, 1);

        // lock exactly on the final sample of the window
        falls = 0;
        do_start(1'b0);
        for (int i = 0; i < RETRY - 1; i++) do_tick(1'b0);
        do_tick(1'b1);
        chk(pass && !fail, "R9", "last-sample lock wins", pass, 1);
        chk(falls == 0 && pll_rstb == 1, "R9", "no reset toggle", falls, 0);

        // both windows time out
        falls = 0;
        do_start(1'b0);
        for (int i = 0; i < RETRY; i++) do_tick(1'b0);
        chk(pll_rstb == 0, "R4", "reset low after timeout", pll_rstb, 0);
        repeat (2) @(negedge clk);
        chk(pll_rstb == 0, "R4", "held low until tick", pll_rstb, 0);
        do_tick(1'b1);
        chk(pll_rstb == 1 && !pass, "R4", "release tick not sampled", pll_rstb, 1);
        for (int i = 0; i < RETRY; i++) do_tick(1'b0);
        chk(fail && done && !pass, "R5", "second timeout fails", fail, 1);
        chk(falls == 1, "R5", "single reset toggle", falls, 1);
        chk(pctl == NDL, "R7", "pctl after fail", pctl, NDL);

        // recovery in the second window
        falls = 0;
        do_start(1'b0);
        for (int i = 0; i < RETRY; i++) do_tick(1'b0);
        do_tick(1'b0);
        for (int i = 0; i < 3; i++) do_tick(1'b0);
        do_tick(1'b1);
        chk(pass && !fail && falls == 1, "R4", "pass after retry", pass, 1);

        // start while busy is ignored
        falls = 0;
        do_start(1'b0);
        do_tick(1'b0); do_tick(1'b0);
        do_start(1'b1);
        do_tick(1'b0); do_tick(1'b0);
        do_tick(1'b1);
        chk(pass && done, "R2", "busy start ignored", pass, 1);

        // super-speed path with stabilisation wait
        do_start(1'b1);
        for (int i = 0; i < STAB; i++) do_tick(1'b1);
        chk(!done && !pass, "R8", "lock ignored in wait", pass, 0);
        chk(pll_rstb == 1, "R8", "rstb high during wait", pll_rstb, 1);
        do_tick(1'b1);
        chk(pass && done, "R8", "first sample after wait", pass, 1);

        // results hold while done
        for (int i = 0; i < 3; i++) begin
            do_tick(1'b0);
            do_tick(1'b1);
        end
        chk(pass && !fail && done, "R6", "verdict held", pass, 1);
        do_start(1'b0);
        chk(!pass && !fail && !done, "R2", "start clears verdict", pass, 0);
        repeat (4) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", checks, errors);
        $finish;
    end

endmodule